// File: doc/BRIEF.md
# Multithread Round-Robin Issue Scheduler

This block selects, on every clock cycle, one hardware thread out of a fixed pool (eight by default) and sends one operation from that thread into a four-stage execution pipeline. Each thread owns a small first-in first-out store of pending instructions, filled from outside one instruction per cycle. Each thread also owns a two-state machine that is either running (`TH_RUN`) or parked (`TH_WAIT`). A thread is parked when the pipeline stub reports that it stalled on a synchroniser, on an input with no data, on an output with no room, or on an event wait. A per-thread wake line returns it to the running state.

Selection rotates in strict ascending thread order, starting after the thread issued most recently. A thread is passed over while its previous operation still occupies stage 1, 2 or 3, so no thread ever holds two operations in the pipeline. When the chosen thread's store is empty, a fetch no-op goes out in its slot so the pipeline can fetch more code for it. A core-level state machine moves between `CORE_ACTIVE` and `CORE_SLEEP` and requests power-down while no thread is running.

Thread transitions are: `TH_WAIT` to `TH_RUN` on wake, and `TH_RUN` to `TH_WAIT` on block. Core transitions are: `CORE_SLEEP` to `CORE_ACTIVE` when some thread will be running, and `CORE_ACTIVE` to `CORE_SLEEP` when none will be.

Top module: `mtis_issue_sched`

## Requirements
- R1: After reset every thread is in `TH_WAIT`, `pwr_down` is 1, and `iss_vld` and `ret_vld` are 0.
- R2: A parked thread whose `wake` bit is 1 at a rising edge is running after that edge; it can appear on the issue outputs one cycle later.
- R3: A running thread whose `block` bit is 1 at a rising edge is parked after that edge, and nothing is issued for it until it is woken.
- R4: Issue goes to the first eligible thread in ascending order, wrapping from N-1 to 0, starting just after the thread issued last (thread 0 is searched first after reset).
- R5: A thread whose operation sits in stage 1, 2 or 3 is not eligible; it becomes eligible again while that operation is in stage 4. One thread alone can therefore issue at most once every 4 cycles.
- R6: When the chosen thread's store holds instructions, the oldest one is issued with `iss_fetch`=0 and removed from the store.
- R7: When the chosen thread's store is empty, a fetch no-op is issued with `iss_fetch`=1 and `iss_instr`=0.
- R8: Each thread's store holds 4 instructions; a fill aimed at a thread whose store is full is dropped.
- R9: `pwr_down` is 1 exactly when no thread is in `TH_RUN` (the core is in `CORE_SLEEP`).
- R10: An operation shown on the issue outputs (stage 1) appears on `ret_vld`/`ret_tid` (stage 4) three cycles later.
- R11: With n threads running and never stalled by R5 (n at least 4), each thread receives exactly one of every n issue slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake | input | N_THREADS | Per-thread wake request (bit t for thread t) |
| block | input | N_THREADS | Per-thread stall report from the pipeline stub |
| fill_vld | input | 1 | Write one instruction into a thread's store |
| fill_tid | input | log2(N_THREADS) | Thread that receives the fill |
| fill_instr | input | INSTR_W | Instruction word written by the fill |
| iss_vld | output | 1 | Stage 1 holds an issued operation |
| iss_tid | output | log2(N_THREADS) | Thread of the stage-1 operation |
| iss_fetch | output | 1 | Stage-1 operation is a fetch no-op |
| iss_instr | output | INSTR_W | Instruction word in stage 1 (0 for a no-op) |
| ret_vld | output | 1 | Stage 4 holds an operation |
| ret_tid | output | log2(N_THREADS) | Thread of the stage-4 operation |
| pwr_down | output | 1 | No thread is running; the core may enter low power |

## Verification
A corrupted thread state shows up either as an issue slot granted to a parked thread or as a running thread that is skipped. The second case breaks the expected rotation on the first cycle the thread should have been picked. A stale rotation pointer or a wrong busy mask changes `iss_tid` within one cycle, and a thread that is wrongly allowed to issue while busy shows up as a second operation from the same thread less than four cycles after the first. Errors in store occupancy surface when the store is drained: an instruction is missing or repeated, or a fetch no-op appears earlier or later than the count of accepted fills predicts.

// File: rtl/mtis_pkg.sv
package mtis_pkg;

    typedef enum logic {
        TH_WAIT = 1'b0,
        TH_RUN  = 1'b1
    } th_state_e;

    typedef enum logic {
        CORE_SLEEP  = 1'b0,
        CORE_ACTIVE = 1'b1
    } core_state_e;

endpackage

// File: rtl/mtis_thread_fsm.sv
module mtis_thread_fsm
    import mtis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic block,
    output logic run_q,
    output logic run_nxt
);

    th_state_e st_q;
    th_state_e st_d;

    // next-state logic
    always_comb begin
        unique case (st_q)
            TH_WAIT: st_d = wake  ? TH_RUN  : TH_WAIT;
            TH_RUN:  st_d = block ? TH_WAIT : TH_RUN;
            default: st_d = TH_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TH_WAIT;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        run_q   = (st_q == TH_RUN);
        run_nxt = (st_d == TH_RUN);
    end

endmodule

// File: rtl/mtis_ibuf.sv
module mtis_ibuf #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             do_push;
    logic             do_pop;

    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CNT_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                cnt <= cnt + 1'b1;
            else if (do_pop && !do_push)
                cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/mtis_rr_pick.sv
module mtis_rr_pick #(
    parameter int N     = 8,
    parameter int TID_W = $clog2(N)
) (
    input  logic [N-1:0]     elig,
    input  logic [TID_W-1:0] last_tid,
    output logic             pick_vld,
    output logic [TID_W-1:0] pick_tid
);

    always_comb begin
        pick_vld = 1'b0;
        pick_tid = '0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (int'(last_tid) + off) % N;
            if (!pick_vld && elig[idx]) begin
                pick_vld = 1'b1;
                pick_tid = TID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/mtis_pipe.sv
module mtis_pipe #(
    parameter int N      = 8,
    parameter int W      = 32,
    parameter int STAGES = 4,
    parameter int TID_W  = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [TID_W-1:0]        in_tid,
    input  logic                    in_fetch,
    input  logic [W-1:0]            in_instr,
    output logic [STAGES-1:0]       st_vld,
    output logic [STAGES*TID_W-1:0] st_tid_flat,
    output logic                    s1_fetch,
    output logic [W-1:0]            s1_instr,
    output logic [N-1:0]            busy
);

    logic [TID_W-1:0] tid_q [STAGES];

    // stage 1 also carries the operation payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_fetch <= 1'b0;
            s1_instr <= '0;
        end else begin
            s1_fetch <= in_vld && in_fetch;
            s1_instr <= in_vld ? in_instr : '0;
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_vld[g] <= 1'b0;
                    tid_q[g]  <= '0;
                end else begin
                    st_vld[g] <= in_vld;
                    tid_q[g]  <= in_tid;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_vld[g] <= 1'b0;
                    tid_q[g]  <= '0;
                end else begin
                    st_vld[g] <= st_vld[g-1];
                    tid_q[g]  <= tid_q[g-1];
                end
            end
        end
        assign st_tid_flat[g*TID_W +: TID_W] = tid_q[g];
    end

    // a thread is busy while its operation is in any stage but the last
    always_comb begin
        busy = '0;
        for (int s = 0; s < STAGES - 1; s++) begin
            if (st_vld[s]) busy[tid_q[s]] = 1'b1;
        end
    end

endmodule

// File: rtl/mtis_issue_sched.sv
module mtis_issue_sched
    import mtis_pkg::*;
#(
    parameter int N_THREADS   = 8,
    parameter int IBUF_DEPTH  = 4,
    parameter int INSTR_W     = 32,
    parameter int PIPE_STAGES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_THREADS-1:0]         wake,
    input  logic [N_THREADS-1:0]         block,
    input  logic                         fill_vld,
    input  logic [$clog2(N_THREADS)-1:0] fill_tid,
    input  logic [INSTR_W-1:0]           fill_instr,
    output logic                         iss_vld,
    output logic [$clog2(N_THREADS)-1:0] iss_tid,
    output logic                         iss_fetch,
    output logic [INSTR_W-1:0]           iss_instr,
    output logic                         ret_vld,
    output logic [$clog2(N_THREADS)-1:0] ret_tid,
    output logic                         pwr_down
);

    localparam int TID_W = $clog2(N_THREADS);

    logic [N_THREADS-1:0]         thr_run;
    logic [N_THREADS-1:0]         thr_run_nxt;
    logic [N_THREADS-1:0]         buf_empty;
    logic [INSTR_W-1:0]           buf_head [N_THREADS];
    logic [N_THREADS-1:0]         busy;
    logic [N_THREADS-1:0]         elig;
    logic                         pick_vld;
    logic [TID_W-1:0]             pick_tid;
    logic [TID_W-1:0]             last_q;
    logic                         pick_fetch;
    logic [INSTR_W-1:0]           pick_instr;
    logic [PIPE_STAGES-1:0]       st_vld;
    logic [PIPE_STAGES*TID_W-1:0] st_tid_flat;
    core_state_e                  core_q;
    core_state_e                  core_d;

    // per-thread run state and instruction store
    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
        mtis_thread_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .wake    (wake[t]),
            .block   (block[t]),
            .run_q   (thr_run[t]),
            .run_nxt (thr_run_nxt[t])
        );

        mtis_ibuf #(
            .DEPTH (IBUF_DEPTH),
            .W     (INSTR_W)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (fill_vld && (fill_tid == TID_W'(t))),
            .push_data (fill_instr),
            .pop       (pick_vld && (pick_tid == TID_W'(t))),
            .empty     (buf_empty[t]),
            .head      (buf_head[t])
        );
    end

    assign elig = thr_run & ~busy;

    mtis_rr_pick #(
        .N     (N_THREADS),
        .TID_W (TID_W)
    ) u_pick (
        .elig     (elig),
        .last_tid (last_q),
        .pick_vld (pick_vld),
        .pick_tid (pick_tid)
    );

    // rotation pointer: starts so that thread 0 is searched first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        last_q <= TID_W'(N_THREADS - 1);
        else if (pick_vld) last_q <= pick_tid;
    end

    always_comb begin
        pick_fetch = buf_empty[pick_tid];
        pick_instr = pick_fetch ? '0 : buf_head[pick_tid];
    end

    mtis_pipe #(
        .N      (N_THREADS),
        .W      (INSTR_W),
        .STAGES (PIPE_STAGES),
        .TID_W  (TID_W)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_vld      (pick_vld),
        .in_tid      (pick_tid),
        .in_fetch    (pick_fetch),
        .in_instr    (pick_instr),
        .st_vld      (st_vld),
        .st_tid_flat (st_tid_flat),
        .s1_fetch    (iss_fetch),
        .s1_instr    (iss_instr),
        .busy        (busy)
    );

    assign iss_vld = st_vld[0];
    assign iss_tid = st_tid_flat[TID_W-1:0];
    assign ret_vld = st_vld[PIPE_STAGES-1];
    assign ret_tid = st_tid_flat[(PIPE_STAGES-1)*TID_W +: TID_W];

    // core power state machine: next state
    always_comb begin
        unique case (core_q)
            CORE_SLEEP:  core_d = (|thr_run_nxt) ? CORE_ACTIVE : CORE_SLEEP;
            CORE_ACTIVE: core_d = (|thr_run_nxt) ? CORE_ACTIVE : CORE_SLEEP;
            default:     core_d = CORE_SLEEP;
        endcase
    end

    // core power state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= CORE_SLEEP;
        else        core_q <= core_d;
    end

    // core power state machine: outputs
    always_comb begin
        pwr_down = (core_q == CORE_SLEEP);
    end

endmodule

// File: rtl/mtis_issue_chk.sv
module mtis_issue_chk #(
    parameter int N      = 8,
    parameter int W      = 32,
    parameter int STAGES = 4,
    parameter int TID_W  = $clog2(N)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    iss_vld,
    input logic [TID_W-1:0]        iss_tid,
    input logic                    iss_fetch,
    input logic [W-1:0]            iss_instr,
    input logic                    ret_vld,
    input logic [TID_W-1:0]        ret_tid,
    input logic                    pwr_down,
    input logic [N-1:0]            thr_run,
    input logic [STAGES-1:0]       st_vld,
    input logic [STAGES*TID_W-1:0] st_tid_flat
);

    // R9
    sleep_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down == (thr_run == '0));

    // R7
    fetch_nop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && iss_fetch) |-> (iss_instr == '0));

    // R3
    issue_running_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> ((($past(thr_run)) >> iss_tid) & N'(1)) != '0);

    // R5
    for (genvar s = 1; s < STAGES; s++) begin : g_one
        single_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_vld[0] && st_vld[s]) |->
                (st_tid_flat[TID_W-1:0] != st_tid_flat[s*TID_W +: TID_W]));
    end

    // R10
    if (STAGES == 4) begin : g_ret
        retire_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(iss_vld, 3) |-> (ret_vld && ret_tid == $past(iss_tid, 3)));
    end

endmodule

bind mtis_issue_sched mtis_issue_chk #(
    .N      (N_THREADS),
    .W      (INSTR_W),
    .STAGES (PIPE_STAGES),
    .TID_W  ($clog2(N_THREADS))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_vld     (iss_vld),
    .iss_tid     (iss_tid),
    .iss_fetch   (iss_fetch),
    .iss_instr   (iss_instr),
    .ret_vld     (ret_vld),
    .ret_tid     (ret_tid),
    .pwr_down    (pwr_down),
    .thr_run     (thr_run),
    .st_vld      (st_vld),
    .st_tid_flat (st_tid_flat)
);

// File: tb/mtis_issue_sched_bench.sv
`timescale 1ns/1ps
module mtis_issue_sched_bench;

    localparam int N  = 8;
    localparam int TW = 3;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  wake = '0;
    logic [N-1:0]  block = '0;
    logic          fill_vld = 1'b0;
    logic [TW-1:0] fill_tid = '0;
    logic [IW-1:0] fill_instr = '0;
    logic          iss_vld;
    logic [TW-1:0] iss_tid;
    logic          iss_fetch;
    logic [IW-1:0] iss_instr;
    logic          ret_vld;
    logic [TW-1:0] ret_tid;
    logic          pwr_down;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mtis_issue_sched u_mtis_issue_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake       (wake),
        .block      (block),
        .fill_vld   (fill_vld),
        .fill_tid   (fill_tid),
        .fill_instr (fill_instr),
        .iss_vld    (iss_vld),
        .iss_tid    (iss_tid),
        .iss_fetch  (iss_fetch),
        .iss_instr  (iss_instr),
        .ret_vld    (ret_vld),
        .ret_tid    (ret_tid),
        .pwr_down   (pwr_down)
    );

    typedef struct packed {
        logic [N-1:0]  wk;
        logic [N-1:0]  bl;
        logic          fv;
        logic [TW-1:0] ft;
        logic [IW-1:0] fi;
        logic          ev;
        logic [TW-1:0] et;
        logic          ef;
        logic [IW-1:0] ei;
        logic          ep;
    } vec_t;

    // each row: inputs applied at one edge, outputs expected just after it
    localparam vec_t TBL [11] = '{
        '{8'h00, 8'h00, 1'b1, 3'd2, 32'hA000_0000, 1'b0, 3'd0, 1'b0, 32'h0,          1'b1},
        '{8'h04, 8'h00, 1'b1, 3'd2, 32'hA000_0001, 1'b0, 3'd0, 1'b0, 32'h0,          1'b0},
        '{8'h20, 8'h00, 1'b0, 3'd0, 32'h0,         1'b1, 3'd2, 1'b0, 32'hA000_0000, 1'b0},
        '{8'h00, 8'h00, 1'b0, 3'd0, 32'h0,         1'b1, 3'd5, 1'b1, 32'h0,          1'b0},
        '{8'h00, 8'h00, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 1'b0, 32'h0,          1'b0},
        '{8'h00, 8'h00, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 1'b0, 32'h0,          1'b0},
        '{8'h00, 8'h04, 1'b0, 3'd0, 32'h0,         1'b1, 3'd2, 1'b0, 32'hA000_0001, 1'b0},
        '{8'h00, 8'h20, 1'b0, 3'd0, 32'h0,         1'b1, 3'd5, 1'b1, 32'h0,          1'b1},
        '{8'h04, 8'h00, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 1'b0, 32'h0,          1'b0},
        '{8'h00, 8'h00, 1'b0, 3'd0, 32'h0,         1'b0, 3'd0, 1'b0, 32'h0,          1'b0},
        '{8'h00, 8'h00, 1'b0, 3'd0, 32'h0,         1'b1, 3'd2, 1'b1, 32'h0,          1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wake = '0; block = '0; fill_vld = 1'b0; fill_tid = '0; fill_instr = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt [N];
        int seq4 [4];

        // R1: reset state
        do_reset();
        chk("R1 pwr_down", 64'(pwr_down), 64'd1);
        chk("R1 iss_vld", 64'(iss_vld), 64'd0);
        chk("R1 ret_vld", 64'(ret_vld), 64'd0);

        // table walk: R2 wake, R3 block, R5 spacing, R6 pop, R7 no-op, R9 power
        for (int r = 0; r < 11; r++) begin
            wake       = TBL[r].wk;
            block      = TBL[r].bl;
            fill_vld   = TBL[r].fv;
            fill_tid   = TBL[r].ft;
            fill_instr = TBL[r].fi;
            step();
            chk($sformatf("R2/R3/R5 row%0d iss_vld", r), 64'(iss_vld), 64'(TBL[r].ev));
            if (TBL[r].ev) begin
                chk($sformatf("R4 row%0d iss_tid", r), 64'(iss_tid), 64'(TBL[r].et));
                chk($sformatf("R6/R7 row%0d iss_fetch", r), 64'(iss_fetch), 64'(TBL[r].ef));
                chk($sformatf("R6/R7 row%0d iss_instr", r), 64'(iss_instr), 64'(TBL[r].ei));
            end
            chk($sformatf("R9 row%0d pwr_down", r), 64'(pwr_down), 64'(TBL[r].ep));
        end
        wake = '0; block = '0; fill_vld = 1'b0;

        // R4, R10, R11: all eight running, strict rotation
        do_reset();
        wake = '1;
        step();
        wake = '0;
        for (int t = 0; t < N; t++) cnt[t] = 0;
        for (int k = 0; k < 32; k++) begin
            step();
            chk("R4 rotation iss_vld", 64'(iss_vld), 64'd1);
            chk("R4 rotation iss_tid", 64'(iss_tid), 64'(k % N));
            chk("R7 empty store fetch", 64'(iss_fetch), 64'd1);
            if (k >= 3) begin
                chk("R10 ret_vld", 64'(ret_vld), 64'd1);
                chk("R10 ret_tid", 64'(ret_tid), 64'((k - 3) % N));
            end
            if (iss_vld) cnt[iss_tid]++;
        end
        for (int t = 0; t < N; t++) chk("R11 share of 8", 64'(cnt[t]), 64'd4);

        // R3, R4, R11: four threads blocked, rotation skips them
        do_reset();
        wake = '1;
        step();
        wake = '0;
        block = 8'h5A;
        step();
        block = '0;
        chk("R4 first after wake", 64'(iss_tid), 64'd0);
        seq4 = '{2, 5, 7, 0};
        for (int t = 0; t < N; t++) cnt[t] = 0;
        for (int k = 0; k < 16; k++) begin
            step();
            chk("R3 subset iss_vld", 64'(iss_vld), 64'd1);
            chk("R3 subset iss_tid", 64'(iss_tid), 64'(seq4[k % 4]));
            if (iss_vld) cnt[iss_tid]++;
        end
        chk("R11 share t2", 64'(cnt[2]), 64'd4);
        chk("R3 blocked t1 share", 64'(cnt[1]), 64'd0);

        // R8, R6, R5: five fills into a 4-deep store, single thread spacing
        do_reset();
        for (int i = 0; i < 5; i++) begin
            fill_vld = 1'b1; fill_tid = 3'd0; fill_instr = 32'h100 + 32'(i);
            step();
        end
        fill_vld = 1'b0;
        wake = 8'h01;
        step();
        wake = '0;
        for (int j = 1; j <= 20; j++) begin
            bit slot;
            int idx;
            step();
            slot = ((j - 1) % 4) == 0;
            idx  = (j - 1) / 4;
            chk("R5 single thread spacing", 64'(iss_vld), 64'(slot));
            if (slot) begin
                if (idx < 4) begin
                    chk("R6 pop order fetch", 64'(iss_fetch), 64'd0);
                    chk("R6 pop order instr", 64'(iss_instr), 64'(32'h100 + 32'(idx)));
                end else begin
                    chk("R8 overflow dropped fetch", 64'(iss_fetch), 64'd1);
                    chk("R8 overflow dropped instr", 64'(iss_instr), 64'd0);
                end
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule